// File: doc/BRIEF.md
# Cross-Context Register Read Unit

This block carries out one instruction: read a register out of another thread context of a small multithreaded core and return 32 bits of it for the issuing thread. The unit holds four thread contexts. Each context has 64-bit general registers, 64-bit floating-point registers, 32-bit floating-point control registers, a 64-bit multiply Lo/Hi pair with its extension, three more accumulator sets, an accumulator control word, a bank of 32-bit system-control registers, and a binding tag that names the processing element that owns the context.

The instruction word is presented together with a pulse on `start`. The context to read does not come from the instruction. It comes from a target field that a separate control register supplies on `tgt_ctx`. The unit decodes the word and checks the opcode and the access rights. It then picks the register class and the index, selects one half of the 64-bit source, and registers the result, the destination index and a write enable. Reads that are denied or that fall out of range return all ones and do not trap. A load port lets any register and any binding tag be preloaded.

Top module: `xrr_unit`

## Requirements
- R1: Word layout from bit 31 down: major opcode [31:26] must be 001000, rt [25:21], rs [20:16], reserved [15:11] must be zero, u [10], minor code [9:4] must be 100011, h [3], sel [2:0]. Any mismatch raises `exc_ri` with `res_we` low. On every accepted start, `res_rt` carries bits [25:21].
- R2: With a valid word and `cop0_en` low, `exc_cu` is raised and `res_we` stays low.
- R3: With `multi_priv` low and an in-range target whose binding tag differs from the issuer's tag, the result is 32'hFFFFFFFF and is written. With `multi_priv` high, or with equal tags, the real value is returned.
- R4: A `tgt_ctx` value above the highest implemented context (3) returns 32'hFFFFFFFF and is written.
- R5: With u=0, system-control register row rs, column sel of the target is read, sign-extended from 32 to 64 bits. Rows 0 to 7 exist. rs of 8 or more returns 32'hFFFFFFFF.
- R6: With u=1 and sel=0, general register rs of the target is read.
- R7: With u=1 and sel=1, rs selects the accumulators. rs 0/1/2 give Lo/Hi/extension of set 0. rs 4k, 4k+1 and 4k+2 give Lo, Hi and extension of set k, for k=1..3. rs 16 gives the accumulator control word.
- R8: With u=1 and sel=2, FP register rs is read. In matched-width mode (`fp_wide`=0) a read with h=1 is undefined.
- R9: With u=1 and sel=3, FP control register rs is read, sign-extended from 32 bits.
- R10: h=1 returns bits 63..32 of the 64-bit source, h=0 returns bits 31..0.
- R11: Undefined selections return zero with `undef_flag` and `res_we` high. These are sel=1 with any rs not listed in R7, sel of 4 to 7 with u=1, and the FP case in R8.
- R12: All outputs are registered. `res_valid` is high exactly in the cycle after a `start` cycle. The flags and `res_we` are low in every other cycle, and all of them are low after reset.
- R13: A write on the load port (classes GPR, FPR, FCR, SYS at index {row,col}, ACC_LO/HI/EXT at set index, ACC_CTL, BIND) is seen by any read that starts on a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load port write strobe |
| ld_ctx | input | 2 | Context to load |
| ld_cls | input | 4 | Register class to load (package enum) |
| ld_idx | input | 6 | Register index within the class |
| ld_data | input | 64 | Load data (low bits used by narrow classes) |
| start | input | 1 | Begin one read |
| instr | input | 32 | Instruction word |
| tgt_ctx | input | 3 | Target context from the control register |
| iss_ctx | input | 2 | Issuing context |
| multi_priv | input | 1 | Issuer may read contexts of other processing elements |
| cop0_en | input | 1 | System coprocessor usable by the issuer |
| fp_wide | input | 1 | 1: FP registers wider than GPRs; 0: matched width |
| res_valid | output | 1 | Result cycle |
| res_we | output | 1 | Destination write enable |
| res_rt | output | 5 | Destination register index |
| res_data | output | 32 | Result data |
| exc_ri | output | 1 | Reserved-instruction exception |
| exc_cu | output | 1 | Coprocessor-unusable exception |
| undef_flag | output | 1 | Undefined selection (debug) |

## Verification
A wrong decode of class or index shows up on `res_data` in the cycle after the start. Each read returns a value that was preloaded at random, so a read from the wrong context, register class, set or half differs from the expected value almost every time. A binding tag or range compare that goes wrong flips the result to or from all ones on that same cycle. A bad exception priority shows up at once as a wrong `exc_ri`/`exc_cu`/`res_we` combination. Stale flag state shows up as a `res_valid` or flag seen on an idle cycle.

// File: rtl/xrr_pkg.sv
package xrr_pkg;
  typedef enum logic [3:0] {
    CLS_GPR     = 4'd0,
    CLS_FPR     = 4'd1,
    CLS_FCR     = 4'd2,
    CLS_SYS     = 4'd3,
    CLS_ACC_LO  = 4'd4,
    CLS_ACC_HI  = 4'd5,
    CLS_ACC_EXT = 4'd6,
    CLS_ACC_CTL = 4'd7,
    CLS_BIND    = 4'd8
  } xrr_cls_e;

  localparam logic [5:0] OPC_MAJOR = 6'b001000;
  localparam logic [5:0] OPC_MINOR = 6'b100011;
  localparam int         SYS_ROWS  = 8;
  localparam int         SYS_COLS  = 8;
endpackage

// File: rtl/xrr_decode.sv
module xrr_decode
  import xrr_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        fp_wide,
  output logic        op_ok,
  output logic [4:0]  rt,
  output xrr_cls_e    rd_cls,
  output logic [5:0]  rd_idx,
  output logic        half,
  output logic        undef,
  output logic        unimpl
);
  logic [4:0] rs;
  logic       u;
  logic [2:0] sel;

  assign rs    = instr[20:16];
  assign u     = instr[10];
  assign sel   = instr[2:0];
  assign half  = instr[3];
  assign rt    = instr[25:21];
  assign op_ok = (instr[31:26] == OPC_MAJOR) && (instr[9:4] == OPC_MINOR) &&
                 (instr[15:11] == 5'd0);

  always_comb begin
    rd_cls = CLS_GPR;
    rd_idx = {1'b0, rs};
    undef  = 1'b0;
    unimpl = 1'b0;
    if (!u) begin
      rd_cls = CLS_SYS;
      rd_idx = {rs[2:0], sel};
      unimpl = (int'(rs) >= SYS_ROWS);
    end else begin
      case (sel)
        3'd0: rd_cls = CLS_GPR;
        3'd1: begin
          if (rs == 5'd16) begin
            rd_cls = CLS_ACC_CTL;
            rd_idx = 6'd0;
          end else if (!rs[4] && rs[1:0] != 2'b11) begin
            rd_idx = {4'd0, rs[3:2]};
            case (rs[1:0])
              2'b00:   rd_cls = CLS_ACC_LO;
              2'b01:   rd_cls = CLS_ACC_HI;
              default: rd_cls = CLS_ACC_EXT;
            endcase
          end else begin
            undef = 1'b1;
          end
        end
        3'd2: begin
          rd_cls = CLS_FPR;
          undef  = !fp_wide && half;
        end
        3'd3: rd_cls = CLS_FCR;
        default: undef = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/xrr_ctx_regs.sv
module xrr_ctx_regs
  import xrr_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int NGPR    = 32,
  parameter int NFPR    = 32,
  parameter int NFCR    = 32,
  parameter int NACC    = 4,
  parameter int BIND_W  = 2,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int GI_W   = $clog2(NGPR),
  localparam int FI_W   = $clog2(NFPR),
  localparam int CI_W   = $clog2(NFCR),
  localparam int AI_W   = $clog2(NACC),
  localparam int NSYS   = SYS_ROWS * SYS_COLS,
  localparam int SI_W   = $clog2(NSYS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [CTX_W-1:0]  ld_ctx,
  input  xrr_cls_e          ld_cls,
  input  logic [5:0]        ld_idx,
  input  logic [63:0]       ld_data,
  input  logic [CTX_W-1:0]  rd_ctx,
  input  xrr_cls_e          rd_cls,
  input  logic [5:0]        rd_idx,
  output logic [63:0]       rd_data,
  input  logic [CTX_W-1:0]  bind_a_ctx,
  output logic [BIND_W-1:0] bind_a,
  input  logic [CTX_W-1:0]  bind_b_ctx,
  output logic [BIND_W-1:0] bind_b
);
  logic [63:0]       gpr_q  [NUM_CTX][NGPR];
  logic [63:0]       fpr_q  [NUM_CTX][NFPR];
  logic [31:0]       fcr_q  [NUM_CTX][NFCR];
  logic [31:0]       sys_q  [NUM_CTX][NSYS];
  logic [63:0]       lo_q   [NUM_CTX][NACC];
  logic [63:0]       hi_q   [NUM_CTX][NACC];
  logic [63:0]       ext_q  [NUM_CTX][NACC];
  logic [63:0]       ctl_q  [NUM_CTX];
  logic [BIND_W-1:0] bind_q [NUM_CTX];

  logic gpr_we, fpr_we, fcr_we, sys_we, lo_we, hi_we, ext_we, ctl_we, bind_we;

  always_comb begin
    gpr_we  = ld_en && ld_cls == CLS_GPR     && int'(ld_idx) < NGPR;
    fpr_we  = ld_en && ld_cls == CLS_FPR     && int'(ld_idx) < NFPR;
    fcr_we  = ld_en && ld_cls == CLS_FCR     && int'(ld_idx) < NFCR;
    sys_we  = ld_en && ld_cls == CLS_SYS     && int'(ld_idx) < NSYS;
    lo_we   = ld_en && ld_cls == CLS_ACC_LO  && int'(ld_idx) < NACC;
    hi_we   = ld_en && ld_cls == CLS_ACC_HI  && int'(ld_idx) < NACC;
    ext_we  = ld_en && ld_cls == CLS_ACC_EXT && int'(ld_idx) < NACC;
    ctl_we  = ld_en && ld_cls == CLS_ACC_CTL;
    bind_we = ld_en && ld_cls == CLS_BIND;
  end

  always_ff @(posedge clk) if (gpr_we) gpr_q[ld_ctx][ld_idx[GI_W-1:0]] <= ld_data;
  always_ff @(posedge clk) if (fpr_we) fpr_q[ld_ctx][ld_idx[FI_W-1:0]] <= ld_data;
  always_ff @(posedge clk) if (fcr_we) fcr_q[ld_ctx][ld_idx[CI_W-1:0]] <= ld_data[31:0];
  always_ff @(posedge clk) if (sys_we) sys_q[ld_ctx][ld_idx[SI_W-1:0]] <= ld_data[31:0];
  always_ff @(posedge clk) if (lo_we)  lo_q[ld_ctx][ld_idx[AI_W-1:0]]  <= ld_data;
  always_ff @(posedge clk) if (hi_we)  hi_q[ld_ctx][ld_idx[AI_W-1:0]]  <= ld_data;
  always_ff @(posedge clk) if (ext_we) ext_q[ld_ctx][ld_idx[AI_W-1:0]] <= ld_data;
  always_ff @(posedge clk) if (ctl_we) ctl_q[ld_ctx] <= ld_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CTX; c++) bind_q[c] <= '0;
    end else if (bind_we) begin
      bind_q[ld_ctx] <= ld_data[BIND_W-1:0];
    end
  end

  always_comb begin
    case (rd_cls)
      CLS_GPR:     rd_data = gpr_q[rd_ctx][rd_idx[GI_W-1:0]];
      CLS_FPR:     rd_data = fpr_q[rd_ctx][rd_idx[FI_W-1:0]];
      CLS_FCR:     rd_data = {{32{fcr_q[rd_ctx][rd_idx[CI_W-1:0]][31]}},
                              fcr_q[rd_ctx][rd_idx[CI_W-1:0]]};
      CLS_SYS:     rd_data = {{32{sys_q[rd_ctx][rd_idx[SI_W-1:0]][31]}},
                              sys_q[rd_ctx][rd_idx[SI_W-1:0]]};
      CLS_ACC_LO:  rd_data = lo_q[rd_ctx][rd_idx[AI_W-1:0]];
      CLS_ACC_HI:  rd_data = hi_q[rd_ctx][rd_idx[AI_W-1:0]];
      CLS_ACC_EXT: rd_data = ext_q[rd_ctx][rd_idx[AI_W-1:0]];
      CLS_ACC_CTL: rd_data = ctl_q[rd_ctx];
      default:     rd_data = '0;
    endcase
  end

  assign bind_a = bind_q[bind_a_ctx];
  assign bind_b = bind_q[bind_b_ctx];

  AST_BIND_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    bind_we |=> bind_q[$past(ld_ctx)] == $past(ld_data[BIND_W-1:0])); // R13
endmodule

// File: rtl/xrr_unit.sv
module xrr_unit
  import xrr_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int TGT_W   = 3,
  parameter int BIND_W  = 2,
  parameter int NGPR    = 32,
  parameter int NFPR    = 32,
  parameter int NFCR    = 32,
  parameter int NACC    = 4,
  localparam int CTX_W  = $clog2(NUM_CTX)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CTX_W-1:0] ld_ctx,
  input  logic [3:0]       ld_cls,
  input  logic [5:0]       ld_idx,
  input  logic [63:0]      ld_data,
  input  logic             start,
  input  logic [31:0]      instr,
  input  logic [TGT_W-1:0] tgt_ctx,
  input  logic [CTX_W-1:0] iss_ctx,
  input  logic             multi_priv,
  input  logic             cop0_en,
  input  logic             fp_wide,
  output logic             res_valid,
  output logic             res_we,
  output logic [4:0]       res_rt,
  output logic [31:0]      res_data,
  output logic             exc_ri,
  output logic             exc_cu,
  output logic             undef_flag
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              op_ok, half, undef, unimpl;
  logic [4:0]        rt;
  xrr_cls_e          rd_cls;
  logic [5:0]        rd_idx;
  logic [63:0]       rd_data;
  logic [BIND_W-1:0] bind_tgt, bind_iss;
  logic [CTX_W-1:0]  tgt_lo;
  logic              in_range, denied;

  assign tgt_lo = tgt_ctx[CTX_W-1:0];

  xrr_decode u_dec (
    .instr  (instr),
    .fp_wide(fp_wide),
    .op_ok  (op_ok),
    .rt     (rt),
    .rd_cls (rd_cls),
    .rd_idx (rd_idx),
    .half   (half),
    .undef  (undef),
    .unimpl (unimpl)
  );

  xrr_ctx_regs #(
    .NUM_CTX(NUM_CTX), .NGPR(NGPR), .NFPR(NFPR), .NFCR(NFCR),
    .NACC(NACC), .BIND_W(BIND_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ld_en     (ld_en),
    .ld_ctx    (ld_ctx),
    .ld_cls    (xrr_cls_e'(ld_cls)),
    .ld_idx    (ld_idx),
    .ld_data   (ld_data),
    .rd_ctx    (tgt_lo),
    .rd_cls    (rd_cls),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .bind_a_ctx(tgt_lo),
    .bind_a    (bind_tgt),
    .bind_b_ctx(iss_ctx),
    .bind_b    (bind_iss)
  );

  // next state
  logic        we_d, ri_d, cu_d, undef_d;
  logic [31:0] data_d;

  always_comb begin
    in_range = (tgt_ctx <= TGT_W'(NUM_CTX - 1));
    denied   = !multi_priv && in_range && (bind_tgt != bind_iss);
    we_d     = 1'b0;
    ri_d     = 1'b0;
    cu_d     = 1'b0;
    undef_d  = 1'b0;
    data_d   = '0;
    if (!op_ok) begin
      ri_d = start;
    end else if (!cop0_en) begin
      cu_d = start;
    end else if (denied || !in_range || unimpl) begin
      we_d   = start;
      data_d = '1;
    end else if (undef) begin
      we_d    = start;
      undef_d = start;
    end else begin
      we_d   = start;
      data_d = half ? rd_data[63:32] : rd_data[31:0];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_valid  <= 1'b0;
      res_we     <= 1'b0;
      exc_ri     <= 1'b0;
      exc_cu     <= 1'b0;
      undef_flag <= 1'b0;
    end else begin
      res_valid  <= start;
      res_we     <= we_d;
      exc_ri     <= ri_d;
      exc_cu     <= cu_d;
      undef_flag <= undef_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_rt   <= '0;
      res_data <= '0;
    end else if (start) begin
      res_rt   <= rt;
      res_data <= data_d;
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    start |=> res_valid); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !start |=> !res_valid && !res_we && !exc_ri && !exc_cu && !undef_flag); // R12
  AST_RT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_int_n)
    start |=> res_rt == $past(instr[25:21])); // R1
  AST_BAD_MAJOR_TRAPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    start && instr[31:26] != OPC_MAJOR |=> exc_ri && !res_we); // R1
  AST_CU_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    start && op_ok && !cop0_en |=> exc_cu && !res_we); // R2
  AST_WE_NOT_WITH_EXC: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_we |-> !exc_ri && !exc_cu); // R2
  AST_RANGE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_int_n)
    start && op_ok && cop0_en && (int'(tgt_ctx) > NUM_CTX - 1) |=> res_we && res_data == '1); // R4
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    undef_flag |-> res_we && res_data == '0); // R11
endmodule

// File: tb/xrr_unit_tb_top.sv
module xrr_unit_tb_top;
  import xrr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [1:0]  ld_ctx;
  logic [3:0]  ld_cls;
  logic [5:0]  ld_idx;
  logic [63:0] ld_data;
  logic        start;
  logic [31:0] instr;
  logic [2:0]  tgt_ctx;
  logic [1:0]  iss_ctx;
  logic        multi_priv, cop0_en, fp_wide;
  logic        res_valid, res_we, exc_ri, exc_cu, undef_flag;
  logic [4:0]  res_rt;
  logic [31:0] res_data;

  always #2.5 clk = ~clk;

  xrr_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_ctx(ld_ctx), .ld_cls(ld_cls), .ld_idx(ld_idx), .ld_data(ld_data),
    .start(start), .instr(instr), .tgt_ctx(tgt_ctx), .iss_ctx(iss_ctx),
    .multi_priv(multi_priv), .cop0_en(cop0_en), .fp_wide(fp_wide),
    .res_valid(res_valid), .res_we(res_we), .res_rt(res_rt), .res_data(res_data),
    .exc_ri(exc_ri), .exc_cu(exc_cu), .undef_flag(undef_flag)
  );

  // bench-side shadow of preloaded state
  logic [63:0] m_gpr [4][32];
  logic [63:0] m_fpr [4][32];
  logic [31:0] m_fcr [4][32];
  logic [31:0] m_sys [4][64];
  logic [63:0] m_lo  [4][4];
  logic [63:0] m_hi  [4][4];
  logic [63:0] m_ext [4][4];
  logic [63:0] m_ctl [4];
  logic [1:0]  m_bind[4];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] rs,
                                     input logic u, input logic [2:0] sel, input logic h);
    return {6'b001000, rt, rs, 5'd0, u, 6'b100011, h, sel};
  endfunction

  // returns {ri, cu, undef, we, data[31:0]}
  function automatic logic [35:0] expect_of(input logic [31:0] ins, input logic [2:0] tgt,
                                            input logic [1:0] iss, input logic priv,
                                            input logic cop, input logic fpw);
    logic [4:0]  rs  = ins[20:16];
    logic        u   = ins[10];
    logic        h   = ins[3];
    logic [2:0]  sel = ins[2:0];
    logic [1:0]  t   = tgt[1:0];
    logic [63:0] src = '0;
    logic        und = 1'b0;
    logic        inr, den, unimpl;
    if (ins[31:26] != 6'b001000 || ins[9:4] != 6'b100011 || ins[15:11] != 5'd0)
      return {4'b1000, 32'd0};
    if (!cop) return {4'b0100, 32'd0};
    inr    = (tgt <= 3'd3);
    den    = !priv && inr && (m_bind[t] != m_bind[iss]);
    unimpl = !u && (rs >= 5'd8);
    if (den || !inr || unimpl) return {4'b0001, 32'hFFFF_FFFF};
    if (!u) src = {{32{m_sys[t][{rs[2:0], sel}][31]}}, m_sys[t][{rs[2:0], sel}]};
    else case (sel)
      3'd0: src = m_gpr[t][rs];
      3'd1: begin
        if (rs == 5'd16) src = m_ctl[t];
        else if (rs < 5'd16 && rs[1:0] != 2'b11) begin
          case (rs[1:0])
            2'b00:   src = m_lo[t][rs[3:2]];
            2'b01:   src = m_hi[t][rs[3:2]];
            default: src = m_ext[t][rs[3:2]];
          endcase
        end else und = 1'b1;
      end
      3'd2: begin src = m_fpr[t][rs]; und = !fpw && h; end
      3'd3: src = {{32{m_fcr[t][rs][31]}}, m_fcr[t][rs]};
      default: und = 1'b1;
    endcase
    if (und) return {4'b0011, 32'd0};
    return {4'b0001, h ? src[63:32] : src[31:0]};
  endfunction

  task automatic ld(input int c, input xrr_cls_e k, input int i, input logic [63:0] d);
    ld_en = 1'b1; ld_ctx = c[1:0]; ld_cls = k; ld_idx = i[5:0]; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  // one read: drive at a falling edge, sample at the next falling edge
  task automatic op(input string req, input logic [31:0] ins, input logic [2:0] tgt,
                    input logic [1:0] iss, input logic priv, input logic cop, input logic fpw);
    logic [35:0] e;
    logic [43:0] a, x;
    e = expect_of(ins, tgt, iss, priv, cop, fpw);
    start = 1'b1; instr = ins; tgt_ctx = tgt; iss_ctx = iss;
    multi_priv = priv; cop0_en = cop; fp_wide = fpw;
    @(negedge clk);
    start = 1'b0;
    a = {res_valid, exc_ri, exc_cu, undef_flag, res_we,
         res_we ? res_data : 32'd0, res_we ? res_rt : 5'd0, 2'b00};
    x = {1'b1, e[35:32], e[32] ? e[31:0] : 32'd0, e[32] ? ins[25:21] : 5'd0, 2'b00};
    chk(req, {20'd0, a}, {20'd0, x});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd7719);
    rst_n = 1'b0; ld_en = 1'b0; ld_ctx = '0; ld_cls = '0; ld_idx = '0; ld_data = '0;
    start = 1'b0; instr = '0; tgt_ctx = '0; iss_ctx = '0;
    multi_priv = 1'b0; cop0_en = 1'b1; fp_wide = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 reset", {59'd0, res_valid, res_we, exc_ri, exc_cu, undef_flag}, 64'd0);

    // preload (R13)
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 32; i++) begin
        m_gpr[c][i] = r64(); ld(c, CLS_GPR, i, m_gpr[c][i]);
        m_fpr[c][i] = r64(); ld(c, CLS_FPR, i, m_fpr[c][i]);
        m_fcr[c][i] = $urandom; ld(c, CLS_FCR, i, {32'd0, m_fcr[c][i]});
      end
      for (int i = 0; i < 64; i++) begin
        m_sys[c][i] = $urandom; ld(c, CLS_SYS, i, {32'd0, m_sys[c][i]});
      end
      for (int i = 0; i < 4; i++) begin
        m_lo[c][i]  = r64(); ld(c, CLS_ACC_LO,  i, m_lo[c][i]);
        m_hi[c][i]  = r64(); ld(c, CLS_ACC_HI,  i, m_hi[c][i]);
        m_ext[c][i] = r64(); ld(c, CLS_ACC_EXT, i, m_ext[c][i]);
      end
      m_ctl[c]  = r64();           ld(c, CLS_ACC_CTL, 0, m_ctl[c]);
      m_bind[c] = (c < 2) ? 2'd0 : 2'd1; ld(c, CLS_BIND, 0, {62'd0, m_bind[c]});
    end
    // force sign bits on one system and one FP control register
    m_sys[1][{3'd3, 3'd5}] = 32'h8000_1234; ld(1, CLS_SYS, {3'd3, 3'd5}, 64'h8000_1234);
    m_fcr[2][7] = 32'hC0DE_0001;            ld(2, CLS_FCR, 7, 64'hC0DE_0001);

    // R1: decode errors
    op("R1 bad major",    {6'b001001, mk(5'd3, 5'd1, 1'b1, 3'd0, 1'b0)}[31:0] | 32'h0400_0000, 3'd0, 2'd0, 1, 1, 1);
    op("R1 bad minor",    mk(5'd3, 5'd1, 1'b1, 3'd0, 1'b0) ^ 32'h0000_0010, 3'd0, 2'd0, 1, 1, 1);
    op("R1 reserved set", mk(5'd3, 5'd1, 1'b1, 3'd0, 1'b0) | 32'h0000_0800, 3'd0, 2'd0, 1, 1, 1);
    op("R1 rt capture",   mk(5'd29, 5'd2, 1'b1, 3'd0, 1'b0), 3'd1, 2'd1, 1, 1, 1);
    // R2
    op("R2 cop0 off",     mk(5'd4, 5'd2, 1'b1, 3'd0, 1'b0), 3'd0, 2'd0, 1, 0, 1);
    // R3
    op("R3 deny other pe",  mk(5'd5, 5'd6, 1'b1, 3'd0, 1'b0), 3'd2, 2'd0, 0, 1, 1);
    op("R3 priv other pe",  mk(5'd5, 5'd6, 1'b1, 3'd0, 1'b0), 3'd2, 2'd0, 1, 1, 1);
    op("R3 same pe",        mk(5'd5, 5'd6, 1'b1, 3'd0, 1'b1), 3'd1, 2'd0, 0, 1, 1);
    // R4
    op("R4 tgt 4",  mk(5'd6, 5'd1, 1'b1, 3'd0, 1'b0), 3'd4, 2'd0, 1, 1, 1);
    op("R4 tgt 7",  mk(5'd6, 5'd1, 1'b1, 3'd0, 1'b0), 3'd7, 2'd0, 1, 1, 1);
    op("R4 tgt 3",  mk(5'd6, 5'd1, 1'b1, 3'd0, 1'b0), 3'd3, 2'd3, 1, 1, 1);
    // R5
    op("R5 sys low",    mk(5'd7, 5'd3, 1'b0, 3'd5, 1'b0), 3'd1, 2'd0, 1, 1, 1);
    op("R5 sys signfill", mk(5'd7, 5'd3, 1'b0, 3'd5, 1'b1), 3'd1, 2'd0, 1, 1, 1);
    op("R5 sys unimpl", mk(5'd7, 5'd9, 1'b0, 3'd0, 1'b0), 3'd1, 2'd0, 1, 1, 1);
    // R6 / R10
    op("R6 R10 gpr31 high", mk(5'd8, 5'd31, 1'b1, 3'd0, 1'b1), 3'd3, 2'd2, 0, 1, 1);
    op("R6 R10 gpr31 low",  mk(5'd8, 5'd31, 1'b1, 3'd0, 1'b0), 3'd3, 2'd2, 0, 1, 1);
    // R7 / R11: sweep rs for accumulators
    for (int r = 0; r < 20; r++)
      op((r == 16 || (r < 16 && r % 4 != 3)) ? "R7 acc map" : "R11 acc undef",
         mk(5'd9, 5'(r), 1'b1, 3'd1, r[0]), 3'(r % 4), 2'd0, 1, 1, 1);
    // R8
    op("R8 fpr wide high",    mk(5'd10, 5'd12, 1'b1, 3'd2, 1'b1), 3'd0, 2'd0, 1, 1, 1);
    op("R8 fpr matched low",  mk(5'd10, 5'd12, 1'b1, 3'd2, 1'b0), 3'd0, 2'd0, 1, 1, 0);
    op("R8 R11 fpr matched high", mk(5'd10, 5'd12, 1'b1, 3'd2, 1'b1), 3'd0, 2'd0, 1, 1, 0);
    // R9
    op("R9 fcr signfill", mk(5'd11, 5'd7, 1'b1, 3'd3, 1'b1), 3'd2, 2'd3, 1, 1, 1);
    op("R9 fcr low",      mk(5'd11, 5'd7, 1'b1, 3'd3, 1'b0), 3'd2, 2'd3, 1, 1, 1);
    // R11
    op("R11 sel6", mk(5'd12, 5'd0, 1'b1, 3'd6, 1'b0), 3'd0, 2'd0, 1, 1, 1);
    op("R11 sel7", mk(5'd12, 5'd0, 1'b1, 3'd7, 1'b1), 3'd0, 2'd0, 1, 1, 1);
    op("R11 sel4", mk(5'd12, 5'd0, 1'b1, 3'd4, 1'b0), 3'd0, 2'd0, 1, 1, 1);
    // R12: idle cycle after a read
    @(negedge clk);
    chk("R12 idle", {59'd0, res_valid, res_we, exc_ri, exc_cu, undef_flag}, 64'd0);
    // R13: reload then read back, and a rebinding
    m_gpr[2][5] = 64'hDEAD_BEEF_0123_4567; ld(2, CLS_GPR, 5, m_gpr[2][5]);
    op("R13 reload gpr", mk(5'd13, 5'd5, 1'b1, 3'd0, 1'b1), 3'd2, 2'd2, 0, 1, 1);
    m_bind[3] = 2'd0; ld(3, CLS_BIND, 0, 64'd0);
    op("R13 R3 rebind", mk(5'd13, 5'd5, 1'b1, 3'd0, 1'b0), 3'd3, 2'd0, 0, 1, 1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      w = mk(5'($urandom), 5'($urandom), 1'($urandom), 3'($urandom), 1'($urandom));
      if ($urandom_range(0, 19) == 0) w ^= 32'(1) << $urandom_range(0, 31);
      op("R5 R6 R7 R8 R9 R10 random", w, 3'($urandom_range(0, 5)), 2'($urandom),
         1'($urandom), ($urandom_range(0, 9) != 0), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule